// File: doc/BRIEF.md
# Interrupt-Activated Transfer Engine

This block moves data between memory addresses on behalf of peripherals and software. A peripheral raises a level flag; when that source is enabled, the engine looks up a pointer in a vector table and reads a five-word descriptor from the address it finds there. The descriptor holds a mode word, a source address, a destination address and two counters. The engine then performs either a single unit transfer (normal mode) or a whole block (block mode), in bytes or in 16-bit words. It writes the updated addresses and counters back to the descriptor and finishes the activation. While the count has not run out, the engine clears the peripheral's flag and the CPU never sees the request. On the last transfer the engine leaves the flag set, drops the source's enable, and the flag then reaches the CPU.

Software can start the engine with a vector number of its own choosing. All memory traffic uses one request channel with valid/ready. A request, once raised, holds its address, direction, data and byte enables unchanged until ready is seen high at a clock edge. Read data returns on a separate response strobe, which the engine takes in any cycle. Only one read is ever outstanding, so the response needs no back-pressure.

Top module: `irq_xfer_ctrl`

## Requirements
- R1: After reset no memory request is raised, `done_o`, `sw_ack_o` and every `flag_clr_o` bit are low, and every source enable is clear.
- R2: A software activation (level `sw_req_i` while idle, no peripheral pending) first reads the 16-bit descriptor pointer at `VEC_BASE + 2*sw_vec_i`; vector 0x60 therefore reads address 0x04C0.
- R3: The descriptor is then read as five consecutive 16-bit words at pointer+0, +2, +4, +6, +8: mode, source address, destination address, count A, count B. In the mode word, bits [15:14] are the source address mode, [13:12] the destination address mode, [11:10] the transfer mode (00 normal, 10 block) and bit 8 the size (0 byte, 1 word).
- R4: Each unit reads the source and then writes the destination. Address mode 10 advances that address by the unit size after the unit, and any other code holds it.
- R5: In normal mode exactly one unit moves per activation and count A decrements by one. Source, destination, count A and count B are then written back, in that order, to pointer+2 through pointer+8.
- R6: When an activation is not final, `flag_clr_o` pulses for the active peripheral only, in the cycle `done_o` is high.
- R7: An activation is final when count A reaches 0 (normal) or count B reaches 0 (block). The flag is then not cleared, that source's enable drops, and `cpu_irq_o[i]` equals `irq_i[i]` AND NOT enable[i] at all times.
- R8: In block mode the low byte of count A counts units down. When it hits 0 it is reloaded from the high byte, count B decrements and the activation ends, so a full block moves per activation (0x0606 moves 6 units).
- R9: Byte reads take the low data lane at an even address and the high lane at an odd one. Byte writes drive the byte on both lanes with byte enable 01 (even) or 10 (odd).
- R10: Word units use byte enable 11 and advance an incrementing address by 2.
- R11: While `mem_req_valid_o` is high and `mem_req_ready_i` low, the request and its address, direction and write data stay unchanged into the next cycle.
- R12: Peripheral i is served only while its enable is set (set by `en_set_i[i]`). Its vector is `PERIPH_VEC0 + i`. Among pending sources the lowest index wins, and software comes last.
- R13: `done_o` is a one-cycle pulse at the end of every activation, with `done_end_o` marking a final one and `sw_ack_o` marking a software activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_SRC | Peripheral request flags (level) |
| en_set_i | input | N_SRC | Pulse to set a source enable |
| sw_req_i | input | 1 | Software activation request (level) |
| sw_vec_i | input | VEC_W | Vector number for software activation |
| flag_clr_o | output | N_SRC | Clear pulse to the activating peripheral |
| cpu_irq_o | output | N_SRC | Requests forwarded to the CPU |
| done_o | output | 1 | Activation finished |
| done_end_o | output | 1 | Finished activation was the last |
| sw_ack_o | output | 1 | Finished activation was software |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | 1 write, 0 read |
| mem_req_addr_o | output | 16 | Byte address |
| mem_req_wdata_o | output | 16 | Write data |
| mem_req_be_o | output | 2 | Byte enables of the write |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_rdata_i | input | 16 | Read data (word at even address) |

## Verification
The bench uses the default build: four peripheral sources, the vector table at 0x0400 and peripheral vectors from 0x40. With these values the 0x60 software vector, both data lanes, and the reload of a short block all come within reach. Two peripherals that are enabled and raised in the same cycle exercise the priority order. A pseudo-random ready pattern and a response delay of up to two cycles stall every state that issues or waits on a request.

// File: rtl/irq_xfer_pkg.sv
package irq_xfer_pkg;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int DESC_WORDS = 5;

  localparam logic [1:0] AM_INC   = 2'b10;
  localparam logic [1:0] MD_BLOCK = 2'b10;

  typedef enum logic [3:0] {
    S_IDLE, S_VRD, S_VWT, S_DRD, S_DWT, S_SRD, S_SWT, S_WR, S_WB, S_DONE
  } xfer_state_e;

  typedef struct packed {
    logic [1:0] sm;
    logic [1:0] dm;
    logic [1:0] md;
    logic       sz;
  } xfer_mode_t;

  function automatic xfer_mode_t mode_decode(input logic [DW-1:0] w);
    xfer_mode_t m;
    m.sm = w[15:14];
    m.dm = w[13:12];
    m.md = w[11:10];
    m.sz = w[8];
    return m;
  endfunction
endpackage

// File: rtl/xfer_arb.sv
module xfer_arb #(
  parameter int N_SRC = 4,
  parameter int SRC_W = 3
) (
  input  logic [N_SRC-1:0] req,
  input  logic             sw_req,
  output logic             any,
  output logic             is_sw,
  output logic [SRC_W-1:0] sel
);
  always_comb begin
    any   = (|req) | sw_req;
    is_sw = ~(|req) & sw_req;
    sel   = SRC_W'(N_SRC);
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) sel = SRC_W'(i);
    end
  end
endmodule

// File: rtl/xfer_addr_step.sv
module xfer_addr_step
  import irq_xfer_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [1:0]    am,
  input  logic          sz,
  output logic [AW-1:0] nxt
);
  always_comb begin
    if (am == AM_INC) nxt = addr + (sz ? AW'(2) : AW'(1));
    else              nxt = addr;
  end
endmodule

// File: rtl/xfer_count.sv
module xfer_count
  import irq_xfer_pkg::*;
(
  input  logic [DW-1:0] cra,
  input  logic [DW-1:0] crb,
  input  logic          blk,
  output logic [DW-1:0] cra_n,
  output logic [DW-1:0] crb_n,
  output logic          unit_last,
  output logic          fin
);
  logic [7:0] lo_n;

  always_comb begin
    lo_n = cra[7:0] - 8'd1;
    if (blk) begin
      if (lo_n == 8'd0) begin
        cra_n     = {cra[15:8], cra[15:8]};
        crb_n     = crb - DW'(1);
        unit_last = 1'b1;
      end else begin
        cra_n     = {cra[15:8], lo_n};
        crb_n     = crb;
        unit_last = 1'b0;
      end
      fin = unit_last && (crb_n == '0);
    end else begin
      cra_n     = cra - DW'(1);
      crb_n     = crb;
      unit_last = 1'b1;
      fin       = (cra_n == '0);
    end
  end
endmodule

// File: rtl/irq_xfer_ctrl.sv
module irq_xfer_ctrl
  import irq_xfer_pkg::*;
#(
  parameter int          N_SRC       = 4,
  parameter int          VEC_W       = 8,
  parameter logic [15:0] VEC_BASE    = 16'h0400,
  parameter int          PERIPH_VEC0 = 'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] en_set_i,
  input  logic             sw_req_i,
  input  logic [VEC_W-1:0] sw_vec_i,
  output logic [N_SRC-1:0] flag_clr_o,
  output logic [N_SRC-1:0] cpu_irq_o,
  output logic             done_o,
  output logic             done_end_o,
  output logic             sw_ack_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic             mem_req_we_o,
  output logic [AW-1:0]    mem_req_addr_o,
  output logic [DW-1:0]    mem_req_wdata_o,
  output logic [1:0]       mem_req_be_o,
  input  logic             mem_rsp_valid_i,
  input  logic [DW-1:0]    mem_rsp_rdata_i
);
  localparam int SRC_W = $clog2(N_SRC + 1);
  localparam logic [2:0] LAST_IDX = 3'(DESC_WORDS - 1);

  xfer_state_e      state_q;
  logic [2:0]       idx_q;
  logic [AW-1:0]    ptr_q, sar_q, dar_q;
  logic [DW-1:0]    cra_q, crb_q, data_q;
  xfer_mode_t       mode_q;
  logic [SRC_W-1:0] src_q;
  logic [VEC_W-1:0] vec_q;
  logic             fin_q;
  logic [N_SRC-1:0] en_q;

  logic             arb_any, arb_sw;
  logic [SRC_W-1:0] arb_sel;
  logic [AW-1:0]    sar_n, dar_n;
  logic [DW-1:0]    cra_n, crb_n;
  logic             unit_last, fin_n;
  logic             src_is_sw;
  logic [N_SRC-1:0] src_mask, en_drop;
  logic [AW-1:0]    desc_addr;

  xfer_arb #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_arb (
    .req(irq_i & en_q), .sw_req(sw_req_i),
    .any(arb_any), .is_sw(arb_sw), .sel(arb_sel)
  );

  xfer_addr_step u_src_step (.addr(sar_q), .am(mode_q.sm), .sz(mode_q.sz), .nxt(sar_n));
  xfer_addr_step u_dst_step (.addr(dar_q), .am(mode_q.dm), .sz(mode_q.sz), .nxt(dar_n));

  xfer_count u_cnt (
    .cra(cra_q), .crb(crb_q), .blk(mode_q.md == MD_BLOCK),
    .cra_n(cra_n), .crb_n(crb_n), .unit_last(unit_last), .fin(fin_n)
  );

  assign src_is_sw = (src_q == SRC_W'(N_SRC));
  assign src_mask  = src_is_sw ? '0 : (N_SRC'(1) << src_q);
  assign desc_addr = ptr_q + {12'b0, idx_q, 1'b0};

  assign done_o     = (state_q == S_DONE);
  assign done_end_o = done_o && fin_q;
  assign sw_ack_o   = done_o && src_is_sw;
  assign flag_clr_o = (done_o && !fin_q) ? src_mask : '0;
  assign en_drop    = (done_o && fin_q) ? src_mask : '0;
  assign cpu_irq_o  = irq_i & ~en_q;

  // Memory request decode, Moore on state.
  always_comb begin
    mem_req_valid_o = 1'b0;
    mem_req_we_o    = 1'b0;
    mem_req_addr_o  = '0;
    mem_req_wdata_o = '0;
    mem_req_be_o    = 2'b00;
    unique case (state_q)
      S_VRD: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = VEC_BASE + AW'({vec_q, 1'b0});
      end
      S_DRD: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = desc_addr;
      end
      S_SRD: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = sar_q;
      end
      S_WR: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
        mem_req_addr_o  = dar_q;
        mem_req_wdata_o = mode_q.sz ? data_q : {data_q[7:0], data_q[7:0]};
        mem_req_be_o    = mode_q.sz ? 2'b11 : (dar_q[0] ? 2'b10 : 2'b01);
      end
      S_WB: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
        mem_req_addr_o  = desc_addr;
        mem_req_be_o    = 2'b11;
        case (idx_q)
          3'd1:    mem_req_wdata_o = sar_q;
          3'd2:    mem_req_wdata_o = dar_q;
          3'd3:    mem_req_wdata_o = cra_q;
          default: mem_req_wdata_o = crb_q;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q & ~en_drop) | en_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      ptr_q   <= '0;
      sar_q   <= '0;
      dar_q   <= '0;
      cra_q   <= '0;
      crb_q   <= '0;
      data_q  <= '0;
      mode_q  <= '0;
      src_q   <= '0;
      vec_q   <= '0;
      fin_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (arb_any) begin
          src_q   <= arb_sel;
          vec_q   <= arb_sw ? sw_vec_i : VEC_W'(PERIPH_VEC0) + VEC_W'(arb_sel);
          state_q <= S_VRD;
        end
        S_VRD: if (mem_req_ready_i) state_q <= S_VWT;
        S_VWT: if (mem_rsp_valid_i) begin
          ptr_q   <= mem_rsp_rdata_i;
          idx_q   <= '0;
          state_q <= S_DRD;
        end
        S_DRD: if (mem_req_ready_i) state_q <= S_DWT;
        S_DWT: if (mem_rsp_valid_i) begin
          case (idx_q)
            3'd0:    mode_q <= mode_decode(mem_rsp_rdata_i);
            3'd1:    sar_q  <= mem_rsp_rdata_i;
            3'd2:    dar_q  <= mem_rsp_rdata_i;
            3'd3:    cra_q  <= mem_rsp_rdata_i;
            default: crb_q  <= mem_rsp_rdata_i;
          endcase
          if (idx_q == LAST_IDX) state_q <= S_SRD;
          else begin
            idx_q   <= idx_q + 3'd1;
            state_q <= S_DRD;
          end
        end
        S_SRD: if (mem_req_ready_i) state_q <= S_SWT;
        S_SWT: if (mem_rsp_valid_i) begin
          data_q  <= mode_q.sz ? mem_rsp_rdata_i
                   : {8'h00, (sar_q[0] ? mem_rsp_rdata_i[15:8] : mem_rsp_rdata_i[7:0])};
          state_q <= S_WR;
        end
        S_WR: if (mem_req_ready_i) begin
          sar_q <= sar_n;
          dar_q <= dar_n;
          cra_q <= cra_n;
          crb_q <= crb_n;
          if (unit_last) begin
            fin_q   <= fin_n;
            idx_q   <= 3'd1;
            state_q <= S_WB;
          end else begin
            state_q <= S_SRD;
          end
        end
        S_WB: if (mem_req_ready_i) begin
          if (idx_q == LAST_IDX) state_q <= S_DONE;
          else idx_q <= idx_q + 3'd1;
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R11: a stalled request must not move.
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o) && $stable(mem_req_wdata_o)));

  p_clr_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr_o));

  p_clr_not_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_clr_o) |-> !done_end_o);

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_no_req_in_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_valid_o);

  for (genvar g = 0; g < N_SRC; g++) begin : g_en_chk
    p_en_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q[g]) |-> $past(done_end_o && (src_q == SRC_W'(g))));
  end
endmodule

// File: tb/irq_xfer_ctrl_tb_top.sv
module irq_xfer_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  typedef struct {
    int          kind;   // 0 read, 1 write, 2 done
    logic [15:0] addr;
    logic [15:0] data;
    logic [1:0]  be;
    int          src;
    bit          fin;
    string       req;
  } txn_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] flag = '0;
  logic [NS-1:0] en_set = '0;
  logic sw_req = 1'b0;
  logic [7:0] sw_vec = 8'h60;
  logic [NS-1:0] flag_clr, cpu_irq;
  logic done, done_end, sw_ack;
  logic req_valid, req_ready, req_we;
  logic [15:0] req_addr, req_wdata;
  logic [1:0] req_be;
  logic rsp_valid = 1'b0;
  logic [15:0] rsp_rdata = '0;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  logic [NS-1:0] en_model = '0;
  bit [7:0] dmem [int];
  bit [7:0] mmem [int];
  txn_t q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_xfer_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(flag), .en_set_i(en_set),
    .sw_req_i(sw_req), .sw_vec_i(sw_vec),
    .flag_clr_o(flag_clr), .cpu_irq_o(cpu_irq),
    .done_o(done), .done_end_o(done_end), .sw_ack_o(sw_ack),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_we_o(req_we),
    .mem_req_addr_o(req_addr), .mem_req_wdata_o(req_wdata), .mem_req_be_o(req_be),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_rdata_i(rsp_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] dget(input int a);
    return dmem.exists(a) ? dmem[a] : 8'h00;
  endfunction
  function automatic bit [7:0] mget(input int a);
    return mmem.exists(a) ? mmem[a] : 8'h00;
  endfunction
  function automatic logic [15:0] mr16(input logic [15:0] a);
    return {mget(int'(a) | 1), mget(int'(a) & 32'hFFFE)};
  endfunction

  task automatic wr8(input logic [15:0] a, input logic [7:0] d);
    dmem[int'(a)] = d; mmem[int'(a)] = d;
  endtask
  task automatic wr16(input logic [15:0] a, input logic [15:0] d);
    wr8(a, d[7:0]); wr8(a + 16'd1, d[15:8]);
  endtask
  task automatic mput(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    if (be[0]) mmem[int'({a[15:1], 1'b0})] = d[7:0];
    if (be[1]) mmem[int'({a[15:1], 1'b1})] = d[15:8];
  endtask

  function automatic logic [15:0] mk_mode(input logic [1:0] sm, input logic [1:0] dm,
                                          input logic [1:0] md, input logic sz);
    return {sm, dm, md, 1'b0, sz, 8'h00};
  endfunction
  task automatic set_desc(input logic [15:0] p, input logic [15:0] m, input logic [15:0] s,
                          input logic [15:0] d, input logic [15:0] a, input logic [15:0] b);
    wr16(p, m); wr16(p + 16'd2, s); wr16(p + 16'd4, d); wr16(p + 16'd6, a); wr16(p + 16'd8, b);
  endtask

  task automatic push(input int kind, input logic [15:0] addr, input logic [15:0] data,
                      input logic [1:0] be, input int src, input bit fin, input string req);
    txn_t t;
    t.kind = kind; t.addr = addr; t.data = data; t.be = be; t.src = src; t.fin = fin; t.req = req;
    q.push_back(t);
  endtask

  // Behavioural prediction of one whole activation.
  task automatic predict(input int src, input logic [7:0] vec);
    logic [15:0] va, ptr, mw, sar, dar, cra, crb, d;
    logic [7:0] lo;
    logic [1:0] be;
    bit blk, sz, stop, fin;
    va = 16'h0400 + {7'b0, vec, 1'b0};
    push(0, va, 0, 0, src, 0, (src == NS) ? "R2" : "R12");
    ptr = mr16(va);
    for (int k = 0; k < 5; k++) push(0, ptr + 16'(2*k), 0, 0, src, 0, "R3");
    mw = mr16(ptr); sar = mr16(ptr + 16'd2); dar = mr16(ptr + 16'd4);
    cra = mr16(ptr + 16'd6); crb = mr16(ptr + 16'd8);
    blk = (mw[11:10] == 2'b10); sz = mw[8];
    stop = 0;
    while (!stop) begin
      push(0, sar, 0, 0, src, 0, "R4");
      if (sz) d = mr16(sar);
      else begin
        lo = mget(int'(sar));
        d = {lo, lo};
      end
      be = sz ? 2'b11 : (dar[0] ? 2'b10 : 2'b01);
      push(1, dar, d, be, src, 0, sz ? "R10" : "R9");
      mput(dar, d, be);
      if (mw[15:14] == 2'b10) sar = sar + (sz ? 16'd2 : 16'd1);
      if (mw[13:12] == 2'b10) dar = dar + (sz ? 16'd2 : 16'd1);
      if (blk) begin
        lo = cra[7:0] - 8'd1;
        if (lo == 0) begin
          cra = {cra[15:8], cra[15:8]}; crb = crb - 16'd1; stop = 1;
        end else cra = {cra[15:8], lo};
      end else begin
        cra = cra - 16'd1; stop = 1;
      end
    end
    fin = blk ? (crb == 0) : (cra == 0);
    push(1, ptr + 16'd2, sar, 2'b11, src, 0, blk ? "R8" : "R5"); mput(ptr + 16'd2, sar, 2'b11);
    push(1, ptr + 16'd4, dar, 2'b11, src, 0, blk ? "R8" : "R5"); mput(ptr + 16'd4, dar, 2'b11);
    push(1, ptr + 16'd6, cra, 2'b11, src, 0, blk ? "R8" : "R5"); mput(ptr + 16'd6, cra, 2'b11);
    push(1, ptr + 16'd8, crb, 2'b11, src, 0, blk ? "R8" : "R5"); mput(ptr + 16'd8, crb, 2'b11);
    push(2, 0, 0, 0, src, fin, "R13");
  endtask

  // Bus, response and completion monitor, compared every cycle.
  initial begin
    logic [15:0] lf;
    int rsp_wait;
    bit prev_stall, rdy;
    logic [15:0] p_addr, p_wdata;
    logic p_we;
    txn_t t;
    lf = 16'hACE1; rsp_wait = -1; prev_stall = 0;
    p_addr = '0; p_wdata = '0; p_we = 0;
    req_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        mismatched++; compared++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
      if (rst_n) begin
        chk(cpu_irq == (flag & ~en_model), "R7", "cpu_irq", cpu_irq, flag & ~en_model);
        if (prev_stall)
          chk(req_valid && req_addr == p_addr && req_we == p_we && req_wdata == p_wdata,
              "R11", "stalled request moved", req_addr, p_addr);
      end
      if (rsp_valid) rsp_valid = 1'b0;
      else if (rsp_wait == 0) begin
        rsp_valid = 1'b1; rsp_wait = -1;
      end else if (rsp_wait > 0) rsp_wait--;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rdy = (lf[1:0] != 2'b00);
      req_ready = rdy;
      prev_stall = req_valid && !rdy;
      p_addr = req_addr; p_we = req_we; p_wdata = req_wdata;
      if (req_valid && rdy) begin
        if (q.size() == 0 || q[0].kind == 2) begin
          chk(0, "R12", "unexpected bus request", req_addr, 0);
        end else begin
          t = q.pop_front();
          chk(req_we == (t.kind == 1), t.req, "direction", req_we, t.kind);
          chk(req_addr == t.addr, t.req, "address", req_addr, t.addr);
          if (t.kind == 1) begin
            chk(req_wdata == t.data, t.req, "write data", req_wdata, t.data);
            chk(req_be == t.be, t.req, "byte enable", req_be, t.be);
            if (req_be[0]) dmem[int'({req_addr[15:1], 1'b0})] = req_wdata[7:0];
            if (req_be[1]) dmem[int'({req_addr[15:1], 1'b1})] = req_wdata[15:8];
          end else begin
            rsp_rdata = {dget(int'({req_addr[15:1], 1'b1})), dget(int'({req_addr[15:1], 1'b0}))};
            rsp_wait = int'(lf[3:2]) % 3;
          end
        end
      end
      if (done) begin
        if (q.size() == 0 || q[0].kind != 2) begin
          chk(0, "R13", "unexpected done", done, 0);
        end else begin
          t = q.pop_front();
          chk(done_end == t.fin, "R7", "final flag", done_end, t.fin);
          chk(flag_clr == ((t.src < NS && !t.fin) ? NS'(1) << t.src : '0), "R6", "flag clear",
              flag_clr, (t.src < NS && !t.fin) ? NS'(1) << t.src : 0);
          chk(sw_ack == (t.src == NS), "R13", "software ack", sw_ack, t.src == NS);
          if (t.fin && t.src < NS) en_model[t.src] = 1'b0;
        end
        flag = flag & ~flag_clr;
        if (sw_ack) sw_req = 1'b0;
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wait_q;
    int n;
    n = 0;
    while (q.size() != 0 && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(q.size() == 0, "R13", "activation incomplete", q.size(), 0);
    tick(2);
  endtask

  task automatic enable(input int i);
    en_set = NS'(1) << i; tick(1);
    en_set = '0; en_model[i] = 1'b1;
  endtask

  task automatic fire(input int i);
    predict(i, 8'h40 + 8'(i));
    flag[i] = 1'b1;
    wait_q();
  endtask

  task automatic sw_fire(input logic [7:0] v);
    predict(NS, v);
    sw_vec = v; sw_req = 1'b1;
    wait_q();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      wr8(16'h1000 + 16'(i), 8'(i * 7 + 3));
      wr8(16'h1100 + 16'(i), 8'(i * 13 + 1));
      wr8(16'h1200 + 16'(i), 8'(255 - i));
      wr8(16'h1300 + 16'(i), 8'(i * 5 + 9));
      wr8(16'h1400 + 16'(i), 8'(i ^ 8'hA5));
    end
    wr16(16'h04C0, 16'h0800);
    for (int i = 0; i < NS; i++) wr16(16'h0480 + 16'(2 * i), 16'h0900 + 16'(16 * i));

    tick(3);
    // R1: reset state
    chk(req_valid == 0 && done == 0 && sw_ack == 0 && flag_clr == 0, "R1", "reset outputs",
        {req_valid, done, sw_ack, flag_clr}, 0);
    chk(cpu_irq == 0, "R1", "no forwarded request", cpu_irq, 0);
    rst_n = 1'b1;
    tick(2);
    // R12: a flag without its enable is forwarded, not served
    flag[0] = 1'b1;
    tick(10);
    chk(cpu_irq[0] == 1'b1, "R12", "unenabled flag forwarded", cpu_irq, 1);
    chk(q.size() == 0 && req_valid == 0, "R12", "unenabled flag ignored", req_valid, 0);
    flag[0] = 1'b0;
    tick(1);

    // R2 R5 R9: software, normal byte, fixed source, incrementing odd destination
    set_desc(16'h0800, mk_mode(2'b00, 2'b10, 2'b00, 1'b0), 16'h3000, 16'h2001, 16'd3, 16'h0055);
    wr8(16'h3000, 8'h5A); sw_fire(8'h60);
    wr8(16'h3000, 8'hC3); sw_fire(8'h60);
    wr8(16'h3000, 8'h17); sw_fire(8'h60);

    // R6 R7: peripheral 0 normal byte, odd fixed source
    set_desc(16'h0900, mk_mode(2'b00, 2'b10, 2'b00, 1'b0), 16'h3011, 16'h2100, 16'd2, 16'h0000);
    wr8(16'h3011, 8'h9E);
    enable(0);
    fire(0);
    chk(flag[0] == 0, "R6", "flag cleared mid-count", flag[0], 0);
    wr8(16'h3011, 8'h42);
    fire(0);
    chk(flag[0] == 1 && cpu_irq[0] == 1, "R7", "final request forwarded", cpu_irq, 1);
    tick(20);
    chk(req_valid == 0, "R7", "disabled source idle", req_valid, 0);
    flag[0] = 1'b0; tick(1);

    // R8: peripheral 2 block byte, 6-unit blocks, two blocks
    set_desc(16'h0920, mk_mode(2'b10, 2'b10, 2'b10, 1'b0), 16'h1000, 16'h2200, 16'h0606, 16'd2);
    enable(2);
    fire(2);
    fire(2);
    flag[2] = 1'b0; tick(1);

    // R10: peripheral 3 normal word
    set_desc(16'h0930, mk_mode(2'b10, 2'b10, 2'b00, 1'b1), 16'h1100, 16'h2300, 16'd2, 16'h0000);
    enable(3);
    fire(3);
    fire(3);
    flag[3] = 1'b0; tick(1);

    // R12: priority between two sources raised together
    set_desc(16'h0910, mk_mode(2'b10, 2'b10, 2'b00, 1'b0), 16'h1200, 16'h2400, 16'd5, 16'h0000);
    set_desc(16'h0930, mk_mode(2'b10, 2'b10, 2'b00, 1'b1), 16'h1300, 16'h2500, 16'd4, 16'h0000);
    enable(1); enable(3);
    predict(1, 8'h41); predict(3, 8'h43);
    flag[1] = 1'b1; flag[3] = 1'b1;
    wait_q();

    // R4 R8 R10: block word with fixed destination, single block ends
    set_desc(16'h0920, mk_mode(2'b10, 2'b00, 2'b10, 1'b1), 16'h1400, 16'h2600, 16'h0303, 16'd1);
    enable(2);
    fire(2);
    flag[2] = 1'b0; tick(1);

    // R5: final memory image matches the model
    foreach (mmem[k]) chk(dget(k) == mmem[k], "R5", "memory image", dget(k), mmem[k]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule